// File: doc/BRIEF.md
# Turn-Passing Shared Chip-Select Node

This block is one node of a closed ring of bus masters that share a single SPI chip-select line and a single set of data wires. The right to use the bus is a turn that travels around the ring. Each node watches one link from the node before it and drives one link toward the node after it. The last node's link feeds the first node, which closes the ring.

A node that holds the turn and has local data pending pulls the shared select low. It starts its local SPI engine through a one-cycle start strobe. When the engine reports completion, the node releases the select. A node that holds the turn with nothing pending leaves the select alone and hands the turn on at once. The outgoing link is held low for as long as the node owns the bus, and it is released when the node is finished. The successor treats the rising edge of that line as its turn.

Both line outputs are open-drain drive enables: a node can only pull a line low or let it float. After reset, exactly one node, chosen by a parameter, already holds the turn. Every other node stays silent until the turn reaches it.

Top module: `turn_ring_node`

## Requirements
- R1: While reset is asserted and on leaving it, `link_drive_low`, `sel_drive_low` and `xfer_start` are all 0. These outputs are drive enables: 1 pulls the line low, 0 releases it, and a node never drives a line high.
- R2: After reset, only the node whose `NODE_ID` equals `FIRST_ID` holds the turn. Every other node drives neither line until its predecessor's link has been seen low at least once and has then risen.
- R3: A node drives `sel_drive_low` only while it owns the turn, and `link_drive_low` is 1 for every cycle that `sel_drive_low` is 1. Across a ring, no two nodes drive the select at the same time.
- R4: A rising edge of `link_in` passes through a two-flip-flop synchronizer before the node takes the turn. With data pending, `sel_drive_low` and `link_drive_low` go to 1 exactly 4 clock cycles after `link_in` rises.
- R5: `xfer_start` is a single-cycle pulse. It is issued in the first cycle in which `sel_drive_low` is 1.
- R6: `sel_drive_low` and `link_drive_low` stay at 1 until `xfer_done` is sampled high during the transfer. Both return to 0 together in the following cycle.
- R7: A node that takes the turn while `xfer_pending` is 0 sets `link_drive_low` to 1 for exactly one cycle and never touches `sel_drive_low`. Its link rises again 5 cycles after `link_in` rose.
- R8: In a ring of `NUM_NODES` nodes (10 by default), the turn visits the nodes in ring order. Each node with pending data gets exactly one transfer per visit, in the order the turn reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_in | input | 1 | Level of the predecessor's link line (asynchronous; high means released) |
| link_drive_low | output | 1 | 1 pulls the successor link low, 0 releases it |
| sel_drive_low | output | 1 | 1 pulls the shared chip-select low, 0 releases it |
| xfer_pending | input | 1 | Local engine has data waiting for the bus |
| xfer_start | output | 1 | One-cycle strobe telling the local engine to shift |
| xfer_done | input | 1 | One-cycle strobe from the local engine when shifting has finished |

## Verification
The state of a node is visible only through its two line enables and the start strobe. The bench therefore builds a ring of ten nodes and follows those signals.

A node that wrongly believes it holds the turn shows up within a single lap. Its select overlaps another node's select, or it takes a grant out of ring order. A node that drops or duplicates the turn shows up the same way: the next grant arrives from the wrong node, or never arrives before the queue of expected grants is due.

Timing faults in the synchronizer or the decision stage show at the first hand-off. They move the 4-cycle grant latency or the 5-cycle pass-through latency, or they stretch the one-cycle link pulse.

// File: rtl/turn_ring_pkg.sv
package turn_ring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HOLD   = 3'd1,
    ST_LAUNCH = 3'd2,
    ST_XFER   = 3'd3,
    ST_PASS   = 3'd4
  } turn_state_e;

  // states in which the node keeps its successor link pulled low
  function automatic logic link_low_in(turn_state_e s);
    return (s == ST_LAUNCH) || (s == ST_XFER) || (s == ST_PASS);
  endfunction

  // states in which the node owns the shared select
  function automatic logic sel_low_in(turn_state_e s);
    return (s == ST_LAUNCH) || (s == ST_XFER);
  endfunction

  // ring successor of a node index
  function automatic int unsigned ring_next(int unsigned id, int unsigned n);
    return (id + 1 == n) ? 0 : id + 1;
  endfunction

endpackage

// File: rtl/turn_link_sync.sv
module turn_link_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_in,
  output logic turn_edge
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         seen_q;

  // flops reset to the released (high) level: a rise is only reported
  // after a low has been observed, so nodes wait for the seed node
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= link_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[TOP-1:0], link_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b1;
    else        seen_q <= sync_q[TOP];
  end

  assign turn_edge = sync_q[TOP] & ~seen_q;

  assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    turn_edge |=> !turn_edge);

endmodule

// File: rtl/turn_fsm.sv
module turn_fsm
  import turn_ring_pkg::*;
#(
  parameter bit IS_FIRST = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        turn_edge,
  input  logic        xfer_pending,
  input  logic        xfer_done,
  output turn_state_e state
);
  localparam turn_state_e RESET_STATE = IS_FIRST ? ST_HOLD : ST_IDLE;

  turn_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:   if (turn_edge) state_d = ST_HOLD;
      ST_HOLD:   state_d = xfer_pending ? ST_LAUNCH : ST_PASS;
      ST_LAUNCH: state_d = ST_XFER;
      ST_XFER:   if (xfer_done) state_d = ST_IDLE;
      ST_PASS:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= RESET_STATE;
    else        state <= state_d;
  end

  // a completion seen mid-transfer ends ownership on the next edge
  assert_release_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XFER && xfer_done) |=> (state == ST_IDLE));

  // an edge arriving while the turn is already owned must not restart it
  assert_edge_ignored_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_edge && state == ST_XFER && !xfer_done) |=> (state == ST_XFER));

endmodule

// File: rtl/turn_drive_map.sv
module turn_drive_map
  import turn_ring_pkg::*;
(
  input  turn_state_e state,
  output logic        link_drive_low,
  output logic        sel_drive_low,
  output logic        xfer_start
);
  assign link_drive_low = link_low_in(state);
  assign sel_drive_low  = sel_low_in(state);
  assign xfer_start     = (state == ST_LAUNCH);
endmodule

// File: rtl/turn_ring_node.sv
module turn_ring_node
  import turn_ring_pkg::*;
#(
  parameter int NODE_ID     = 0,
  parameter int FIRST_ID    = 0,
  parameter int NUM_NODES   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_in,
  output logic link_drive_low,
  output logic sel_drive_low,
  input  logic xfer_pending,
  output logic xfer_start,
  input  logic xfer_done
);
  localparam bit IS_FIRST = (NODE_ID == FIRST_ID);

  initial begin
    assert (NODE_ID >= 0 && NODE_ID < NUM_NODES && FIRST_ID < NUM_NODES && NUM_NODES >= 2)
      else $error("turn_ring_node: node index outside ring");
  end

  logic        turn_edge;
  turn_state_e state;

  turn_link_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_in   (link_in),
    .turn_edge (turn_edge)
  );

  turn_fsm #(.IS_FIRST(IS_FIRST)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .turn_edge    (turn_edge),
    .xfer_pending (xfer_pending),
    .xfer_done    (xfer_done),
    .state        (state)
  );

  turn_drive_map u_map (
    .state          (state),
    .link_drive_low (link_drive_low),
    .sel_drive_low  (sel_drive_low),
    .xfer_start     (xfer_start)
  );

  assert_sel_needs_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_drive_low |-> link_drive_low);

  assert_start_with_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_drive_low) |-> xfer_start);

  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_pass_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_drive_low && !sel_drive_low) |=> !link_drive_low);

  assert_release_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_drive_low) |-> !link_drive_low);

endmodule

// File: tb/turn_ring_node_bench.sv
module turn_ring_node_bench;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0] link_dl, sel_dl, start_v, done_v, pend_q, pending_v, load_mask;
  logic         load_stb = 1'b0;
  logic [3:0]   eng_cnt [N];

  int compared = 0;
  int mismatched = 0;
  int exp_q[$];

  for (genvar g = 0; g < N; g++) begin : g_ring
    turn_ring_node #(.NODE_ID(g), .FIRST_ID(0), .NUM_NODES(N)) u_turn_ring_node (
      .clk            (clk),
      .rst_n          (rst_n),
      .link_in        (~link_dl[(g + N - 1) % N]),
      .link_drive_low (link_dl[g]),
      .sel_drive_low  (sel_dl[g]),
      .xfer_pending   (pending_v[g]),
      .xfer_start     (start_v[g]),
      .xfer_done      (done_v[g])
    );
  end

  initial load_mask = '0;
  assign pending_v = pend_q | (load_stb ? load_mask : '0);

  always @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pending_v & ~start_v;
  end

  // local SPI engine stand-ins: variable length per node
  always @(posedge clk) begin
    if (!rst_n) begin
      done_v <= '0;
      for (int i = 0; i < N; i++) eng_cnt[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (start_v[i])            eng_cnt[i] <= 4'(2 + (i % 4));
        else if (eng_cnt[i] != 0)  eng_cnt[i] <= eng_cnt[i] - 1;
        done_v[i] <= (eng_cnt[i] == 1);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor state
  logic [N-1:0] sel_prev = '0, link_prev = '0, done_prev = '0, did = '0;
  int  cnt[N];
  int  low_len[N];
  int  last_rel = N - 1;
  bit  seen0 = 1'b0;

  initial for (int i = 0; i < N; i++) begin cnt[i] = -1; low_len[i] = 0; end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [N-1:0] rose;
      rose = '0;
      if (link_dl[0]) seen0 = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (cnt[i] >= 0) cnt[i]++;
        if (link_dl[i]) low_len[i]++;
      end
      for (int i = 0; i < N; i++) begin
        if (i != 0 && !seen0 && (link_dl[i] || sel_dl[i]))
          check(1'b0, "R2", i, 0);
        if (sel_dl[i] && !sel_prev[i]) begin
          check(seen0, "R2", int'(seen0), 1);
          if (exp_q.size() == 0) check(1'b0, "R8", i, -1);
          else begin
            int e;
            e = exp_q.pop_front();
            check(i == e, "R8", i, e);
          end
          check(start_v[i], "R5", int'(start_v[i]), 1);
          check($countones(sel_dl) == 1, "R3", $countones(sel_dl), 1);
          check(link_dl[i], "R3", int'(link_dl[i]), 1);
          if (cnt[i] >= 0) check(cnt[i] == 4, "R4", cnt[i], 4);
          did[i] = 1'b1;
        end
        if (start_v[i] && sel_prev[i]) check(1'b0, "R5", 1, 0);
        if (done_prev[i])
          check(!sel_dl[i] && !link_dl[i], "R6", int'({sel_dl[i], link_dl[i]}), 0);
        if (link_prev[i] && !link_dl[i]) begin
          if (!did[i]) begin
            check(low_len[i] == 1, "R7", low_len[i], 1);
            if (cnt[i] >= 0) check(cnt[i] == 5, "R7", cnt[i], 5);
          end
          did[i] = 1'b0;
          low_len[i] = 0;
          last_rel = i;
          rose[i] = 1'b1;
        end
      end
      for (int i = 0; i < N; i++)
        if (rose[(i + N - 1) % N]) cnt[i] = 0;
      sel_prev  = sel_dl;
      link_prev = link_dl;
      done_prev = done_v;
    end
  end

  // driver: queue the expected grant order, then raise the requests
  task automatic run_round(input logic [N-1:0] mask);
    int s;
    do begin
      @(negedge clk); #1;
    end while (exp_q.size() != 0 || pend_q != 0 || sel_dl != 0 || start_v != 0);
    s = (last_rel + 1) % N;
    if (link_dl[s]) s = (s + 1) % N;
    for (int k = 0; k < N; k++)
      if (mask[(s + k) % N]) exp_q.push_back((s + k) % N);
    load_mask = mask;
    load_stb  = 1'b1;
    @(negedge clk); #1;
    load_stb  = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++)   // R1 reset state
      check(!link_dl[i] && !sel_dl[i] && !start_v[i], "R1", int'({link_dl[i], sel_dl[i], start_v[i]}), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++)   // R1 released after reset apart from the seed
      if (i != 0) check(!link_dl[i] && !sel_dl[i] && !start_v[i], "R1", int'({link_dl[i], sel_dl[i]}), 0);
    run_round(10'b0010100000);   // R2 nodes 5 and 7 wait for the seed
    run_round('1);               // R8 every node, full lap
    run_round('0);
    run_round(10'b1000000001);   // R8 wrap across the ring closure
    run_round(10'b0000001000);
    run_round(10'b0101010100);
    run_round(10'b0000000001);
    run_round('1);
    do begin
      @(negedge clk); #1;
    end while (exp_q.size() != 0 || sel_dl != 0);
    repeat (60) @(negedge clk);
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule